// File: doc/BRIEF.md
# Nine-Bit Capable Asynchronous Serial Receiver

This block turns an asynchronous serial line into parallel words. A frame is one low start bit, eight or nine data bits sent least significant bit first, and one high stop bit. Timing comes from an external oversampling strobe that pulses sixteen times per bit period. The start bit is confirmed at its middle, and every later bit is sampled once, sixteen strobes after the previous sample.

Optionally the most significant data slot carries a parity bit instead of data. The receiver checks that bit against the other data bits for even or odd parity. A parity failure sets a sticky flag, which can also drive an interrupt line. In nine-bit mode the ninth bit appears on its own output. In address-mark wake mode, a word whose top data bit is set is also reported as an address word. Word length, parity and wake settings are copied into shadow registers when a start bit is confirmed, so a setting changed mid-frame only affects the next frame. A halt input stops new frames from being accepted but lets the current frame finish.

Top module: `nine_bit_uart_rx`

## Requirements
- R1: With `cfg_nine`=0 a frame carries 8 data bits, least significant bit first. They appear on `rx_data`, and `rx_bit8` reads 0.
- R2: With `cfg_nine`=1 a frame carries 9 data bits. The first eight appear on `rx_data` and the ninth on `rx_bit8`.
- R3: With `cfg_par_en`=1 the last data bit of the frame (bit 7 in 8-bit mode, bit 8 in 9-bit mode) is the parity bit. The check is an XOR over all data bits of the frame. With `cfg_par_odd`=0 (even parity) a result of 1 is an error; with `cfg_par_odd`=1 (odd parity) a result of 0 is an error. The data bits are delivered unchanged, including the parity bit. With `cfg_par_en`=0 no parity error is ever raised.
- R4: `perr_flag` is set by a frame with a parity error. It stays set across later frames until `clr_perr` is high on a clock edge; the flag is then 0 in the next cycle. If a new error arrives on the same edge as the clear, the error wins.
- R5: `irq` is 1 exactly when `perr_flag` is set and `cfg_perr_irq_en` was 1 on the previous clock edge. It follows a change of the enable one cycle later.
- R6: Word length, parity enable, parity select and wake mode are captured when the start bit is confirmed. Changes made later in the same frame do not affect that frame's length, parity result or address flag.
- R7: A start bit that reads high at its mid-point (8 strobes after the line is first seen low) is discarded, and no word is delivered.
- R8: A stop bit sampled low sets `ferr_flag` and the word is still delivered. `ferr_flag` is updated only when a word is delivered, and it shows the stop bit of that word.
- R9: `data_ready` is a one-cycle strobe. With a strobe on every clock and the line changing just after a rising edge, it is high in cycle 155 (8-bit) or 171 (9-bit) after the line falls. This count includes the two-stage line synchronizer.
- R10: `addr_frame` pulses together with `data_ready` when wake mode was 1 (address mark) and the top data bit of the word (bit 7 or bit 8, by word length) is 1. In wake mode 0 (idle line) it stays 0.
- R11: While `cfg_halt` is 1 no new frame is started. A frame already past start confirmation is still completed and delivered.
- R12: After synchronous reset every output is 0.
- R13: After a frame the line must be seen high before another start bit is accepted. A line held low after a low stop bit yields no further words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| os_tick | input | 1 | Oversampling strobe, 16 per bit period |
| cfg_nine | input | 1 | Word length: 0 = 8 data bits, 1 = 9 data bits |
| cfg_par_en | input | 1 | 1 = top data slot is checked as parity |
| cfg_par_odd | input | 1 | 0 = even parity, 1 = odd parity |
| cfg_perr_irq_en | input | 1 | Lets the parity flag drive `irq` |
| cfg_wake_addr | input | 1 | Wake mode: 0 = idle line, 1 = address mark |
| cfg_halt | input | 1 | Blocks new frames from starting |
| clr_perr | input | 1 | Clears the parity error flag |
| rx_data | output | 8 | Low eight received data bits |
| rx_bit8 | output | 1 | Ninth received data bit (0 in 8-bit mode) |
| data_ready | output | 1 | One-cycle strobe: new word on the outputs |
| perr_flag | output | 1 | Sticky parity error |
| ferr_flag | output | 1 | Stop bit of the last word was low |
| addr_frame | output | 1 | Last word was an address word (address-mark mode) |
| irq | output | 1 | Parity interrupt request |

## Verification
Delivery timing is checked exactly. The bench changes the line just after a rising edge and reads the cycle counter at the falling edge on which `data_ready` is seen. It expects 155 cycles for an 8-bit frame and 171 for a 9-bit frame with one strobe per clock. Data, the ninth bit, the framing and parity flags and the address flag are all latched from that same strobe cycle, because the design updates them on the same edge. `irq` is checked one cycle after its enable changes, and `perr_flag` one cycle after a clear pulse. Rejected starts, halted frames and a line held low are checked by counting strobes over a window longer than a whole frame.

// File: rtl/uart9_rx_pkg.sv
package uart9_rx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_phase_e;

  typedef struct packed {
    logic nine;
    logic par_en;
    logic par_odd;
    logic wake_addr;
  } rx_cfg_t;

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic line_out
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= line_in;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], line_in};
      end
    end
  endgenerate

  assign line_out = chain[STAGES-1];

endmodule

// File: rtl/rx_frame_ctrl.sv
module rx_frame_ctrl
  import uart9_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int BASE_BITS  = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 line,
  input  logic                 accept_new,
  input  rx_cfg_t              cfg_live,
  output rx_cfg_t              cfg_q,
  output logic                 frame_done,
  output logic                 stop_bit,
  output logic [BASE_BITS:0]   frame_bits
);

  localparam int MAX_BITS = BASE_BITS + 1;
  localparam int CNT_W    = $clog2(OVERSAMPLE);
  localparam int IDX_W    = $clog2(MAX_BITS);
  localparam logic [CNT_W-1:0] MID_LAST = CNT_W'(OVERSAMPLE / 2 - 1);
  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(OVERSAMPLE - 1);
  localparam logic [IDX_W-1:0] IDX_8    = IDX_W'(BASE_BITS - 1);
  localparam logic [IDX_W-1:0] IDX_9    = IDX_W'(BASE_BITS);

  rx_phase_e          phase;
  logic [CNT_W-1:0]   cnt;
  logic [IDX_W-1:0]   idx;
  logic [IDX_W-1:0]   last_idx;
  logic               seen_high;

  assign last_idx   = cfg_q.nine ? IDX_9 : IDX_8;
  assign frame_done = (phase == RX_STOP) && tick && (cnt == BIT_LAST);
  assign stop_bit   = line;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= RX_IDLE;
      cnt        <= '0;
      idx        <= '0;
      frame_bits <= '0;
      cfg_q      <= '0;
      seen_high  <= 1'b0;
    end else begin
      case (phase)
        RX_IDLE: begin
          if (line) seen_high <= 1'b1;
          if (tick && !line && seen_high && accept_new) begin
            phase     <= RX_START;
            cnt       <= '0;
            seen_high <= 1'b0;
          end
        end
        RX_START: begin
          if (tick) begin
            if (cnt == MID_LAST) begin
              cnt <= '0;
              if (!line) begin
                phase      <= RX_DATA;
                idx        <= '0;
                cfg_q      <= cfg_live;
                frame_bits <= '0;
              end else begin
                phase <= RX_IDLE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        RX_DATA: begin
          if (tick) begin
            if (cnt == BIT_LAST) begin
              cnt             <= '0;
              frame_bits[idx] <= line;
              if (idx == last_idx) phase <= RX_STOP;
              else                 idx   <= idx + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        RX_STOP: begin
          if (tick) begin
            if (cnt == BIT_LAST) begin
              cnt   <= '0;
              phase <= RX_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: phase <= RX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rx_parity_eval.sv
module rx_parity_eval
  import uart9_rx_pkg::*;
#(
  parameter int BASE_BITS = 8
) (
  input  logic [BASE_BITS:0] bits,
  input  rx_cfg_t            cfg,
  output logic               par_bad,
  output logic               top_bit
);

  localparam int MAX_BITS = BASE_BITS + 1;

  logic acc;

  always_comb begin
    acc = 1'b0;
    for (int i = 0; i < MAX_BITS; i++) begin
      if ((i < BASE_BITS) || cfg.nine) acc = acc ^ bits[i];
    end
    par_bad = cfg.par_en & (acc ^ cfg.par_odd);
    top_bit = cfg.nine ? bits[BASE_BITS] : bits[BASE_BITS-1];
  end

endmodule

// File: rtl/rx_status_regs.sv
module rx_status_regs
  import uart9_rx_pkg::*;
#(
  parameter int BASE_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 frame_done,
  input  logic [BASE_BITS:0]   bits,
  input  rx_cfg_t              cfg,
  input  logic                 stop_bit,
  input  logic                 par_bad,
  input  logic                 top_bit,
  input  logic                 clr_perr,
  input  logic                 irq_en,
  output logic [BASE_BITS-1:0] rx_data,
  output logic                 rx_bit8,
  output logic                 data_ready,
  output logic                 perr_flag,
  output logic                 ferr_flag,
  output logic                 addr_frame,
  output logic                 irq
);

  logic perr_next;

  assign perr_next = (perr_flag & ~clr_perr) | (frame_done & par_bad);

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data    <= '0;
      rx_bit8    <= 1'b0;
      data_ready <= 1'b0;
      perr_flag  <= 1'b0;
      ferr_flag  <= 1'b0;
      addr_frame <= 1'b0;
      irq        <= 1'b0;
    end else begin
      data_ready <= frame_done;
      addr_frame <= frame_done & cfg.wake_addr & top_bit;
      perr_flag  <= perr_next;
      irq        <= perr_next & irq_en;
      if (frame_done) begin
        rx_data   <= bits[BASE_BITS-1:0];
        rx_bit8   <= cfg.nine & bits[BASE_BITS];
        ferr_flag <= ~stop_bit;
      end
    end
  end

endmodule

// File: rtl/nine_bit_uart_rx.sv
module nine_bit_uart_rx
  import uart9_rx_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int BASE_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rx_line,
  input  logic                 os_tick,
  input  logic                 cfg_nine,
  input  logic                 cfg_par_en,
  input  logic                 cfg_par_odd,
  input  logic                 cfg_perr_irq_en,
  input  logic                 cfg_wake_addr,
  input  logic                 cfg_halt,
  input  logic                 clr_perr,
  output logic [BASE_BITS-1:0] rx_data,
  output logic                 rx_bit8,
  output logic                 data_ready,
  output logic                 perr_flag,
  output logic                 ferr_flag,
  output logic                 addr_frame,
  output logic                 irq
);

  logic               line_s;
  rx_cfg_t            cfg_live;
  rx_cfg_t            cfg_q;
  logic               frame_done;
  logic               stop_bit;
  logic [BASE_BITS:0] frame_bits;
  logic               par_bad;
  logic               top_bit;

  always_comb begin
    cfg_live.nine      = cfg_nine;
    cfg_live.par_en    = cfg_par_en;
    cfg_live.par_odd   = cfg_par_odd;
    cfg_live.wake_addr = cfg_wake_addr;
  end

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .line_in  (rx_line),
    .line_out (line_s)
  );

  rx_frame_ctrl #(.OVERSAMPLE(OVERSAMPLE), .BASE_BITS(BASE_BITS)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .tick       (os_tick),
    .line       (line_s),
    .accept_new (~cfg_halt),
    .cfg_live   (cfg_live),
    .cfg_q      (cfg_q),
    .frame_done (frame_done),
    .stop_bit   (stop_bit),
    .frame_bits (frame_bits)
  );

  rx_parity_eval #(.BASE_BITS(BASE_BITS)) u_par (
    .bits    (frame_bits),
    .cfg     (cfg_q),
    .par_bad (par_bad),
    .top_bit (top_bit)
  );

  rx_status_regs #(.BASE_BITS(BASE_BITS)) u_stat (
    .clk        (clk),
    .rst        (rst),
    .frame_done (frame_done),
    .bits       (frame_bits),
    .cfg        (cfg_q),
    .stop_bit   (stop_bit),
    .par_bad    (par_bad),
    .top_bit    (top_bit),
    .clr_perr   (clr_perr),
    .irq_en     (cfg_perr_irq_en),
    .rx_data    (rx_data),
    .rx_bit8    (rx_bit8),
    .data_ready (data_ready),
    .perr_flag  (perr_flag),
    .ferr_flag  (ferr_flag),
    .addr_frame (addr_frame),
    .irq        (irq)
  );

endmodule

// File: rtl/uart9_rx_chk.sv
module uart9_rx_chk (
  input logic clk,
  input logic rst,
  input logic data_ready,
  input logic perr_flag,
  input logic ferr_flag,
  input logic addr_frame,
  input logic rx_bit8,
  input logic irq,
  input logic clr_perr,
  input logic irq_en,
  input logic frame_done,
  input logic shadow_nine
);

  // R9: the delivery strobe lasts one cycle
  a_r9_ready_single: assert property (@(posedge clk) disable iff (rst)
    data_ready |=> !data_ready);

  // R4: parity flag holds until cleared
  a_r4_perr_sticky: assert property (@(posedge clk) disable iff (rst)
    (perr_flag && !clr_perr) |=> perr_flag);

  // R4: a clear without a competing error empties the flag
  a_r4_perr_clear: assert property (@(posedge clk) disable iff (rst)
    (clr_perr && !frame_done) |=> !perr_flag);

  // R5: interrupt only with the flag set
  a_r5_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
    irq |-> perr_flag);

  // R5: interrupt gated by the enable
  a_r5_irq_gated: assert property (@(posedge clk) disable iff (rst)
    !irq_en |=> !irq);

  // R2: ninth bit is zero for 8-bit words
  a_r2_bit8_zero: assert property (@(posedge clk) disable iff (rst)
    (data_ready && !shadow_nine) |-> !rx_bit8);

  // R10: address indication only with a delivered word
  a_r10_addr_with_ready: assert property (@(posedge clk) disable iff (rst)
    addr_frame |-> data_ready);

  // R8: framing flag changes only with a delivered word
  a_r8_ferr_stable: assert property (@(posedge clk) disable iff (rst)
    !data_ready |-> $stable(ferr_flag));

endmodule

bind nine_bit_uart_rx uart9_rx_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .data_ready  (data_ready),
  .perr_flag   (perr_flag),
  .ferr_flag   (ferr_flag),
  .addr_frame  (addr_frame),
  .rx_bit8     (rx_bit8),
  .irq         (irq),
  .clr_perr    (clr_perr),
  .irq_en      (cfg_perr_irq_en),
  .frame_done  (frame_done),
  .shadow_nine (cfg_q.nine)
);

// File: tb/tb_nine_bit_uart_rx.sv
module tb_nine_bit_uart_rx;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_line = 1'b1;
  logic       os_tick;
  logic       cfg_nine = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
  logic       cfg_perr_irq_en = 1'b0, cfg_wake_addr = 1'b0, cfg_halt = 1'b0;
  logic       clr_perr = 1'b0;
  logic [7:0] rx_data;
  logic       rx_bit8, data_ready, perr_flag, ferr_flag, addr_frame, irq;

  nine_bit_uart_rx dut (
    .clk(clk), .rst(rst), .rx_line(rx_line), .os_tick(os_tick),
    .cfg_nine(cfg_nine), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_perr_irq_en(cfg_perr_irq_en), .cfg_wake_addr(cfg_wake_addr),
    .cfg_halt(cfg_halt), .clr_perr(clr_perr),
    .rx_data(rx_data), .rx_bit8(rx_bit8), .data_ready(data_ready),
    .perr_flag(perr_flag), .ferr_flag(ferr_flag), .addr_frame(addr_frame),
    .irq(irq)
  );

  always #10 clk = ~clk;

  // oversampling strobe: every clock when tick_div is 1
  int tick_div = 1;
  int tphase   = 0;
  always @(posedge clk) tphase <= (tphase + 1 >= tick_div) ? 0 : tphase + 1;
  assign os_tick = (tick_div == 1) ? 1'b1 : (tphase == 0);

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // capture of each delivered word at the falling edge
  int         rdy_cnt = 0, rdy_wide = 0, cap_cyc = 0;
  logic       prev_rdy = 1'b0;
  logic [7:0] cap_data;
  logic       cap_b8, cap_perr, cap_ferr, cap_addr;
  always @(negedge clk) begin
    if (data_ready) begin
      rdy_cnt  <= rdy_cnt + 1;
      cap_cyc  <= cyc;
      cap_data <= rx_data;
      cap_b8   <= rx_bit8;
      cap_perr <= perr_flag;
      cap_ferr <= ferr_flag;
      cap_addr <= addr_frame;
      if (prev_rdy) rdy_wide <= rdy_wide + 1;
    end
    prev_rdy <= data_ready;
  end

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  int fall_cyc = 0;

  task automatic send_frame(input logic nine, input logic [8:0] bits,
                            input logic stop, input int per, input logic idle_lvl);
    @(negedge clk);
    rx_line  = 1'b0;
    fall_cyc = cyc;
    repeat (per) @(negedge clk);
    for (int k = 0; k < (nine ? 9 : 8); k++) begin
      rx_line = bits[k];
      repeat (per) @(negedge clk);
    end
    rx_line = stop;
    repeat (per) @(negedge clk);
    rx_line = idle_lvl;
    repeat (per) @(negedge clk);
  endtask

  task automatic pulse_clear();
    @(negedge clk);
    clr_perr = 1'b1;
    @(negedge clk);
    clr_perr = 1'b0;
  endtask

  // {nine,par_en,par_odd,wake}, bits[8:0], stop, exp_data, {b8,perr,ferr,addr}
  localparam logic [25:0] VECS [12] = '{
    {4'b0000, 9'h0A5, 1'b1, 8'hA5, 4'b0000},  // R1 plain 8-bit
    {4'b1000, 9'h1C3, 1'b1, 8'hC3, 4'b1000},  // R2 ninth bit set
    {4'b0100, 9'h003, 1'b1, 8'h03, 4'b0000},  // R3 even ok
    {4'b0100, 9'h007, 1'b1, 8'h07, 4'b0100},  // R3 even bad
    {4'b0110, 9'h007, 1'b1, 8'h07, 4'b0000},  // R3 odd ok
    {4'b1110, 9'h100, 1'b1, 8'h00, 4'b1000},  // R3 odd ok in 9-bit
    {4'b1100, 9'h101, 1'b1, 8'h01, 4'b1000},  // R3 even ok in 9-bit
    {4'b0001, 9'h080, 1'b1, 8'h80, 4'b0001},  // R10 address word
    {4'b1001, 9'h0FF, 1'b1, 8'hFF, 4'b0000},  // R10 bit 8 clear -> data
    {4'b0000, 9'h05A, 1'b0, 8'h5A, 4'b0010},  // R8 low stop
    {4'b0000, 9'h080, 1'b1, 8'h80, 4'b0000},  // R10 idle-line mode
    {4'b0110, 9'h000, 1'b1, 8'h00, 4'b0100}   // R3 odd bad
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R12 reset state
    check("R12 rx_data", rx_data, 0);
    check("R12 flags", {rx_bit8, data_ready, perr_flag, ferr_flag, addr_frame, irq}, 0);
    repeat (10) @(negedge clk);

    // table of frames
    for (int v = 0; v < 12; v++) begin
      logic [25:0] t;
      t = VECS[v];
      {cfg_nine, cfg_par_en, cfg_par_odd, cfg_wake_addr} = t[25:22];
      pulse_clear();
      base = rdy_cnt;
      send_frame(t[25], t[21:13], t[12], 16, 1'b1);
      check($sformatf("R9 v%0d count", v), rdy_cnt - base, 1);
      check($sformatf("R9 v%0d latency", v), cap_cyc - fall_cyc, t[25] ? 171 : 155);
      check($sformatf("R1 v%0d data", v), cap_data, t[11:4]);
      check($sformatf("R2 v%0d bit8", v), cap_b8, t[3]);
      check($sformatf("R3 v%0d perr", v), cap_perr, t[2]);
      check($sformatf("R8 v%0d ferr", v), cap_ferr, t[1]);
      check($sformatf("R10 v%0d addr", v), cap_addr, t[0]);
    end
    check("R9 single-cycle strobe", rdy_wide, 0);

    // R4 sticky flag, R5 interrupt
    {cfg_nine, cfg_par_en, cfg_par_odd, cfg_wake_addr} = 4'b0100;
    pulse_clear();
    send_frame(1'b0, 9'h007, 1'b1, 16, 1'b1);
    check("R4 set", perr_flag, 1);
    check("R5 irq off while disabled", irq, 0);
    send_frame(1'b0, 9'h003, 1'b1, 16, 1'b1);
    check("R4 held over good frame", perr_flag, 1);
    @(negedge clk);
    cfg_perr_irq_en = 1'b1;
    check("R5 irq not yet", irq, 0);
    @(negedge clk);
    check("R5 irq follows enable", irq, 1);
    cfg_perr_irq_en = 1'b0;
    @(negedge clk);
    check("R5 irq drops with enable", irq, 0);
    cfg_perr_irq_en = 1'b1;
    @(negedge clk);
    clr_perr = 1'b1;
    @(negedge clk);
    clr_perr = 1'b0;
    check("R4 cleared", perr_flag, 0);
    check("R5 irq cleared", irq, 0);
    cfg_perr_irq_en = 1'b0;

    // R6 mid-frame configuration change is ignored
    {cfg_nine, cfg_par_en, cfg_par_odd, cfg_wake_addr} = 4'b0000;
    pulse_clear();
    base = rdy_cnt;
    fork
      send_frame(1'b0, 9'h087, 1'b1, 16, 1'b1);
      begin
        repeat (40) @(negedge clk);
        {cfg_nine, cfg_par_en, cfg_par_odd, cfg_wake_addr} = 4'b1101;
      end
    join
    check("R6 count", rdy_cnt - base, 1);
    check("R6 length kept", cap_cyc - fall_cyc, 155);
    check("R6 parity kept off", cap_perr, 0);
    check("R6 wake kept off", cap_addr, 0);
    check("R6 data", cap_data, 8'h87);
    {cfg_nine, cfg_par_en, cfg_par_odd, cfg_wake_addr} = 4'b0000;

    // R7 short low pulse rejected
    base = rdy_cnt;
    @(negedge clk);
    rx_line = 1'b0;
    repeat (4) @(negedge clk);
    rx_line = 1'b1;
    repeat (200) @(negedge clk);
    check("R7 glitch ignored", rdy_cnt - base, 0);
    send_frame(1'b0, 9'h03C, 1'b1, 16, 1'b1);
    check("R7 recovery count", rdy_cnt - base, 1);
    check("R7 recovery data", cap_data, 8'h3C);

    // R11 halt
    cfg_halt = 1'b1;
    base = rdy_cnt;
    send_frame(1'b0, 9'h011, 1'b1, 16, 1'b1);
    repeat (40) @(negedge clk);
    check("R11 halted no word", rdy_cnt - base, 0);
    cfg_halt = 1'b0;
    repeat (10) @(negedge clk);
    fork
      send_frame(1'b0, 9'h0E2, 1'b1, 16, 1'b1);
      begin
        repeat (60) @(negedge clk);
        cfg_halt = 1'b1;
      end
    join
    check("R11 frame in flight finishes", rdy_cnt - base, 1);
    check("R11 data", cap_data, 8'hE2);
    cfg_halt = 1'b0;

    // R13 line held low after a low stop bit
    repeat (10) @(negedge clk);
    base = rdy_cnt;
    send_frame(1'b0, 9'h055, 1'b0, 16, 1'b0);
    repeat (100) @(negedge clk);
    check("R13 one word only", rdy_cnt - base, 1);
    check("R13 framing flagged", cap_ferr, 1);
    rx_line = 1'b1;
    repeat (20) @(negedge clk);
    send_frame(1'b0, 9'h0AA, 1'b1, 16, 1'b1);
    check("R13 rearmed count", rdy_cnt - base, 2);
    check("R13 rearmed ferr", cap_ferr, 0);
    check("R13 rearmed data", cap_data, 8'hAA);

    // R1 with a strobe every second clock
    tick_div = 2;
    repeat (4) @(negedge clk);
    base = rdy_cnt;
    send_frame(1'b0, 9'h0C9, 1'b1, 32, 1'b1);
    check("R1 slow tick count", rdy_cnt - base, 1);
    check("R1 slow tick data", cap_data, 8'hC9);
    tick_div = 1;

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule